// File: doc/BRIEF.md
# Dual-Issue ALU Instruction Decoder

This block turns one 64-bit instruction word into the control for two execution pipes that run side by side: an add-style pipe and a multiply-style pipe. Each instruction carries an opcode for each pipe and four 3-bit operand selectors. Each selector picks one of six accumulators, the single read port of register file A, or the single read port of register file B. In the small-literal form, the B read address field instead carries an index into a fixed table of constants. The decoder also tests each pipe's condition field against the current Z, N and C flags, sends the two results to their register files under a swap bit, picks which pipe's result updates the flags, and reports when the instruction reads a physical register that the previous accepted instruction wrote.

The decoder is combinational from `instr` and the flags to every output, except `hazard`. `hazard` compares against a small record of the last accepted instruction's physical writes, and that record is updated on each clock edge where `in_valid` is high. Branch, 32-bit load and semaphore words are classified only: they drive no execute, read, write or flag control.

Top module: `dualalu_decode`

## Requirements
- R1: The word is split, from bit 63 down, into signal[63:60], unpack[59:57], pm[56], pack[55:52], cond_add[51:49], cond_mul[48:46], sf[45], ws[44], waddr_add[43:38], waddr_mul[37:32], op_mul[31:29], op_add[28:24], raddr_a[23:18], raddr_b[17:12], add_a[11:9], add_b[8:6], mul_a[5:3], mul_b[2:0]. `iclass` is 2 (branch) for signal 15. For signal 14 it is 4 (semaphore) when unpack is 4 and 3 (32-bit load) otherwise. It is 1 (ALU with literal) for signal 13 and 0 (plain ALU) for every other signal.
- R2: `add_go` / `mul_go` are high only when `in_valid` is high, `iclass` is 0 or 1, the pipe's opcode is non-zero (0 is NOP), and the pipe's condition passes. Condition codes: 0 never, 1 always, 2 Z, 3 not Z, 4 N, 5 not N, 6 C, 7 not C.
- R3: Operand k (0 add_a, 1 add_b, 2 mul_a, 3 mul_b) reports its kind in `src_kind[2k+1:2k]`: 0 accumulator (codes 0 to 5), 1 file A (code 6), 2 file B (code 7), 3 literal (code 7 in the literal form). `src_acc[3k+2:3k]` holds the code for an accumulator and 0 otherwise.
- R4: `rd_a_en` is high when any operand of an active pipe (valid ALU class, non-zero opcode) selects file A, and `rd_b_en` likewise for file B outside the literal form. The ports read `raddr_a` and `raddr_b`. Operands of a NOP pipe never enable a read.
- R5: In the literal form, an active operand with code 7 raises `lit_valid` and leaves `rd_b_en` low. `lit_value` is derived from raddr_b: 0..15 give 0..15, 16..31 give -16..-1, 32..39 give the single-precision values 1.0 to 128.0 in powers of two, 40..47 give 1/256 to 1/2, and 48..63 give 0.
- R6: With ws clear, the add result targets file A (`*_wr_file`=0) and the mul result targets file B (1). With ws set, the two files are exchanged.
- R7: A pipe writes only when its `*_go` is high. Write addresses 0..31 raise `*_wr_phys`, 32..37 raise `*_wr_acc`, 39 raises nothing, and 38 and 40..63 raise `*_wr_io`. `*_wr_addr` carries the address.
- R8: `flag_we` is high for a valid ALU-class word with sf set. `flag_src` is then 1 (mul result) when op_add is 0 or cond_add is 0, and 0 (add result) otherwise. It is 0 whenever `flag_we` is low.
- R9: `hazard` is high when an enabled read port addresses a register below 32 that the last accepted instruction wrote in the same file. Cycles with `in_valid` low leave that record unchanged.
- R10: With `in_valid` low, or for branch, load and semaphore words, all go, read, literal, write, flag, pack and hazard outputs are low.
- R11: Reset clears the write record, so an instruction right after reset never raises `hazard`.
- R12: `pack_ctl` equals {pm, pack} for a valid ALU-class word and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word is present and accepted |
| instr | input | 64 | Instruction word |
| flag_z | input | 1 | Current zero flag |
| flag_n | input | 1 | Current negative flag |
| flag_c | input | 1 | Current carry flag |
| iclass | output | 3 | Instruction class code |
| add_go | output | 1 | Add pipe executes |
| mul_go | output | 1 | Mul pipe executes |
| src_kind | output | 8 | Per-operand source kind, 2 bits each |
| src_acc | output | 12 | Per-operand accumulator index, 3 bits each |
| rd_a_en | output | 1 | File A read port used |
| rd_a_addr | output | 6 | File A read address |
| rd_b_en | output | 1 | File B read port used |
| rd_b_addr | output | 6 | File B read address |
| lit_valid | output | 1 | A literal operand is used |
| lit_value | output | 32 | Literal operand value |
| add_wr_phys | output | 1 | Add result writes a physical register |
| add_wr_acc | output | 1 | Add result writes an accumulator |
| add_wr_io | output | 1 | Add result writes an IO-space location |
| add_wr_file | output | 1 | Add destination file (0 A, 1 B) |
| add_wr_addr | output | 6 | Add destination address |
| mul_wr_phys | output | 1 | Mul result writes a physical register |
| mul_wr_acc | output | 1 | Mul result writes an accumulator |
| mul_wr_io | output | 1 | Mul result writes an IO-space location |
| mul_wr_file | output | 1 | Mul destination file (0 A, 1 B) |
| mul_wr_addr | output | 6 | Mul destination address |
| flag_we | output | 1 | Flags are updated |
| flag_src | output | 1 | Flag source (0 add, 1 mul) |
| pack_ctl | output | 5 | Pack mode bit and pack field |
| hazard | output | 1 | Read of a register written by the previous instruction |

## Verification
The hardest case to reach is a hazard that depends on history: a read must match the previous word's write in both address and file. With the swap bit set, the same address lands in the other file, and an idle cycle between writer and reader must not erase the record. The stimulus places writer/reader pairs back to back with ws clear and then set, inserts an idle bubble between a writer and its reader, and pulses reset between a writer and a reader. The flag-source fallback is driven separately with a NOP add, with a never condition, and with a condition that merely fails.

// File: rtl/ddec_pkg.sv
package ddec_pkg;

  typedef enum logic [2:0] {
    CLS_ALU     = 3'd0,
    CLS_ALU_LIT = 3'd1,
    CLS_BRANCH  = 3'd2,
    CLS_LOADIMM = 3'd3,
    CLS_SEMA    = 3'd4
  } iclass_e;

  typedef enum logic [1:0] {
    SRC_ACC    = 2'd0,
    SRC_FILE_A = 2'd1,
    SRC_FILE_B = 2'd2,
    SRC_LIT    = 2'd3
  } src_kind_e;

  typedef struct packed {
    logic [3:0] signal;
    logic [2:0] unpack;
    logic       pm;
    logic [3:0] pack;
    logic [2:0] cond_add;
    logic [2:0] cond_mul;
    logic       sf;
    logic       ws;
    logic [5:0] waddr_add;
    logic [5:0] waddr_mul;
    logic [2:0] op_mul;
    logic [4:0] op_add;
    logic [5:0] raddr_a;
    logic [5:0] raddr_b;
    logic [2:0] add_a;
    logic [2:0] add_b;
    logic [2:0] mul_a;
    logic [2:0] mul_b;
  } word_fields_t;

  localparam logic [3:0] SIG_BRANCH  = 4'd15;
  localparam logic [3:0] SIG_LOAD    = 4'd14;
  localparam logic [3:0] SIG_LIT     = 4'd13;
  localparam logic [2:0] SEMA_MARK   = 3'd4;

  function automatic iclass_e classify(input word_fields_t f);
    iclass_e c;
    if (f.signal == SIG_BRANCH)      c = CLS_BRANCH;
    else if (f.signal == SIG_LOAD)   c = (f.unpack == SEMA_MARK) ? CLS_SEMA : CLS_LOADIMM;
    else if (f.signal == SIG_LIT)    c = CLS_ALU_LIT;
    else                             c = CLS_ALU;
    return c;
  endfunction

  function automatic logic cond_pass(input logic [2:0] code,
                                     input logic z, input logic n, input logic cy);
    logic r;
    case (code)
      3'd0:    r = 1'b0;
      3'd1:    r = 1'b1;
      3'd2:    r = z;
      3'd3:    r = ~z;
      3'd4:    r = n;
      3'd5:    r = ~n;
      3'd6:    r = cy;
      default: r = ~cy;
    endcase
    return r;
  endfunction

  // Literal table: signed 5-bit integers, then powers of two as IEEE single.
  function automatic logic [31:0] small_lit(input logic [5:0] idx);
    logic [31:0] v;
    logic [7:0]  e;
    e = 8'd0;
    if (idx < 6'd32) begin
      v = {{27{idx[4]}}, idx[4:0]};
    end else if (idx < 6'd40) begin
      e = 8'd127 + {5'd0, idx[2:0]};
      v = {1'b0, e, 23'd0};
    end else if (idx < 6'd48) begin
      e = 8'd119 + {5'd0, idx[2:0]};
      v = {1'b0, e, 23'd0};
    end else begin
      v = 32'd0;
    end
    return v;
  endfunction

endpackage

// File: rtl/ddec_operand.sv
module ddec_operand
  import ddec_pkg::*;
#(
  parameter int ACC_N  = 6,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              lit_form,
  input  logic              active,
  output src_kind_e         kind,
  output logic [CODE_W-1:0] acc_idx,
  output logic              use_a,
  output logic              use_b,
  output logic              use_lit
);

  localparam logic [CODE_W-1:0] CODE_A = CODE_W'(ACC_N);

  always_comb begin
    acc_idx = '0;
    if (code < CODE_A) begin
      kind    = SRC_ACC;
      acc_idx = code;
    end else if (code == CODE_A) begin
      kind = SRC_FILE_A;
    end else begin
      kind = lit_form ? SRC_LIT : SRC_FILE_B;
    end
  end

  assign use_a   = active && (kind == SRC_FILE_A);
  assign use_b   = active && (kind == SRC_FILE_B);
  assign use_lit = active && (kind == SRC_LIT);

  // R5: a literal is only ever taken in the literal form
  p_lit_only_in_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
    use_lit |-> lit_form);

  // R4: an idle operand claims no read port
  p_idle_no_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(use_a || use_b || use_lit));

endmodule

// File: rtl/ddec_dest.sv
module ddec_dest #(
  parameter int AW       = 6,
  parameter int PHYS_N   = 32,
  parameter int ACC_BASE = 32,
  parameter int ACC_N    = 6,
  parameter int NO_WRITE = 39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          to_file_b,
  input  logic [AW-1:0] waddr,
  output logic          wr_phys,
  output logic          wr_acc,
  output logic          wr_io,
  output logic          wr_file,
  output logic [AW-1:0] wr_addr
);

  localparam logic [AW-1:0] PHYS_LIM = AW'(PHYS_N);
  localparam logic [AW-1:0] ACC_LO   = AW'(ACC_BASE);
  localparam logic [AW-1:0] ACC_HI   = AW'(ACC_BASE + ACC_N);
  localparam logic [AW-1:0] NONE_ADR = AW'(NO_WRITE);

  logic tgt_phys, tgt_acc, tgt_none;

  assign tgt_phys = waddr < PHYS_LIM;
  assign tgt_acc  = (waddr >= ACC_LO) && (waddr < ACC_HI);
  assign tgt_none = waddr == NONE_ADR;

  assign wr_phys = go && tgt_phys;
  assign wr_acc  = go && tgt_acc;
  assign wr_io   = go && !tgt_phys && !tgt_acc && !tgt_none;
  assign wr_file = to_file_b;
  assign wr_addr = waddr;

  // R7: the no-write address produces no write of any kind
  p_nowrite_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (waddr == NONE_ADR) |-> !(wr_phys || wr_acc || wr_io));

  // R7: at most one destination class per pipe
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_phys, wr_acc, wr_io}));

endmodule

// File: rtl/ddec_hazard.sv
module ddec_hazard #(
  parameter int AW     = 6,
  parameter int PHYS_N = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          check_en,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic          rd_a_en,
  input  logic [AW-1:0] rd_a_addr,
  input  logic          rd_b_en,
  input  logic [AW-1:0] rd_b_addr,
  output logic          hit_a,
  output logic          hit_b,
  output logic          hazard
);

  localparam logic [AW-1:0] PHYS_LIM = AW'(PHYS_N);

  logic          prev_a_v, prev_b_v;
  logic [AW-1:0] prev_a, prev_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_v <= 1'b0;
      prev_b_v <= 1'b0;
      prev_a   <= '0;
      prev_b   <= '0;
    end else if (accept) begin
      prev_a_v <= wa_en;
      prev_b_v <= wb_en;
      prev_a   <= wa_addr;
      prev_b   <= wb_addr;
    end
  end

  assign hit_a  = check_en && rd_a_en && (rd_a_addr < PHYS_LIM) && prev_a_v && (prev_a == rd_a_addr);
  assign hit_b  = check_en && rd_b_en && (rd_b_addr < PHYS_LIM) && prev_b_v && (prev_b == rd_b_addr);
  assign hazard = hit_a || hit_b;

  // R9: a hazard needs a recorded physical write
  p_hazard_has_record_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> (prev_a_v || prev_b_v));

  // R9: idle cycles keep the record
  p_record_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(prev_a_v) && $stable(prev_b_v)));

endmodule

// File: rtl/dualalu_decode.sv
module dualalu_decode
  import ddec_pkg::*;
#(
  parameter int AW       = 6,
  parameter int DATA_W   = 32,
  parameter int ACC_N    = 6,
  parameter int PHYS_N   = 32,
  parameter int ACC_BASE = 32,
  parameter int NO_WRITE = 39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [63:0]   instr,
  input  logic          flag_z,
  input  logic          flag_n,
  input  logic          flag_c,
  output logic [2:0]    iclass,
  output logic          add_go,
  output logic          mul_go,
  output logic [7:0]    src_kind,
  output logic [11:0]   src_acc,
  output logic          rd_a_en,
  output logic [5:0]    rd_a_addr,
  output logic          rd_b_en,
  output logic [5:0]    rd_b_addr,
  output logic          lit_valid,
  output logic [31:0]   lit_value,
  output logic          add_wr_phys,
  output logic          add_wr_acc,
  output logic          add_wr_io,
  output logic          add_wr_file,
  output logic [5:0]    add_wr_addr,
  output logic          mul_wr_phys,
  output logic          mul_wr_acc,
  output logic          mul_wr_io,
  output logic          mul_wr_file,
  output logic [5:0]    mul_wr_addr,
  output logic          flag_we,
  output logic          flag_src,
  output logic [4:0]    pack_ctl,
  output logic          hazard
);

  localparam int NUM_SRC = 4;
  localparam int N_PIPES = 2;
  localparam int CODE_W  = 3;
  localparam int KIND_W  = 2;

  word_fields_t f;
  iclass_e      cls;
  logic         alu_class, lit_form, live;
  logic         add_active, mul_active;

  assign f         = instr;
  assign cls       = classify(f);
  assign iclass    = cls;
  assign alu_class = (cls == CLS_ALU) || (cls == CLS_ALU_LIT);
  assign lit_form  = cls == CLS_ALU_LIT;
  assign live      = in_valid && alu_class;

  assign add_active = live && (f.op_add != '0);
  assign mul_active = live && (f.op_mul != '0);
  assign add_go     = add_active && cond_pass(f.cond_add, flag_z, flag_n, flag_c);
  assign mul_go     = mul_active && cond_pass(f.cond_mul, flag_z, flag_n, flag_c);

  // Operand resolution
  logic [CODE_W-1:0] mux_code [NUM_SRC];
  src_kind_e         op_kind  [NUM_SRC];
  logic [CODE_W-1:0] op_acc   [NUM_SRC];
  logic [NUM_SRC-1:0] use_a_v, use_b_v, use_lit_v;

  always_comb begin
    mux_code[0] = f.add_a;
    mux_code[1] = f.add_b;
    mux_code[2] = f.mul_a;
    mux_code[3] = f.mul_b;
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    ddec_operand #(.ACC_N(ACC_N), .CODE_W(CODE_W)) u_operand (
      .clk      (clk),
      .rst_n    (rst_n),
      .code     (mux_code[k]),
      .lit_form (lit_form),
      .active   ((k < NUM_SRC / N_PIPES) ? add_active : mul_active),
      .kind     (op_kind[k]),
      .acc_idx  (op_acc[k]),
      .use_a    (use_a_v[k]),
      .use_b    (use_b_v[k]),
      .use_lit  (use_lit_v[k])
    );
    assign src_kind[KIND_W*k +: KIND_W] = op_kind[k];
    assign src_acc[CODE_W*k +: CODE_W]  = op_acc[k];
  end

  assign rd_a_en   = |use_a_v;
  assign rd_b_en   = |use_b_v;
  assign lit_valid = |use_lit_v;
  assign rd_a_addr = f.raddr_a;
  assign rd_b_addr = f.raddr_b;
  assign lit_value = lit_form ? small_lit(f.raddr_b) : '0;

  // Destination steering: pipe 0 is add, pipe 1 is mul
  logic [N_PIPES-1:0] p_go, p_tob, p_phys, p_acc, p_io, p_file;
  logic [AW-1:0]      p_waddr [N_PIPES];
  logic [AW-1:0]      p_oaddr [N_PIPES];

  assign p_go     = {mul_go, add_go};
  assign p_tob    = {~f.ws, f.ws};
  assign p_waddr[0] = f.waddr_add;
  assign p_waddr[1] = f.waddr_mul;

  for (genvar p = 0; p < N_PIPES; p++) begin : g_dst
    ddec_dest #(
      .AW(AW), .PHYS_N(PHYS_N), .ACC_BASE(ACC_BASE), .ACC_N(ACC_N), .NO_WRITE(NO_WRITE)
    ) u_dest (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (p_go[p]),
      .to_file_b (p_tob[p]),
      .waddr     (p_waddr[p]),
      .wr_phys   (p_phys[p]),
      .wr_acc    (p_acc[p]),
      .wr_io     (p_io[p]),
      .wr_file   (p_file[p]),
      .wr_addr   (p_oaddr[p])
    );
  end

  assign add_wr_phys = p_phys[0];
  assign add_wr_acc  = p_acc[0];
  assign add_wr_io   = p_io[0];
  assign add_wr_file = p_file[0];
  assign add_wr_addr = p_oaddr[0];
  assign mul_wr_phys = p_phys[1];
  assign mul_wr_acc  = p_acc[1];
  assign mul_wr_io   = p_io[1];
  assign mul_wr_file = p_file[1];
  assign mul_wr_addr = p_oaddr[1];

  // Flag source: add result unless the add pipe is NOP or never-conditioned
  logic add_flag_dead;
  assign add_flag_dead = (f.op_add == '0) || (f.cond_add == 3'd0);
  assign flag_we       = live && f.sf;
  assign flag_src      = flag_we && add_flag_dead;
  assign pack_ctl      = live ? {f.pm, f.pack} : '0;

  // Physical write record per file, for the read-after-write check
  logic          wa_en, wb_en, hit_a, hit_b;
  logic [AW-1:0] wa_addr, wb_addr;

  assign wa_en   = (add_wr_phys && !add_wr_file) || (mul_wr_phys && !mul_wr_file);
  assign wb_en   = (add_wr_phys &&  add_wr_file) || (mul_wr_phys &&  mul_wr_file);
  assign wa_addr = (add_wr_phys && !add_wr_file) ? add_wr_addr : mul_wr_addr;
  assign wb_addr = (add_wr_phys &&  add_wr_file) ? add_wr_addr : mul_wr_addr;

  ddec_hazard #(.AW(AW), .PHYS_N(PHYS_N)) u_hazard (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (in_valid),
    .check_en  (live),
    .wa_en     (wa_en),
    .wa_addr   (wa_addr),
    .wb_en     (wb_en),
    .wb_addr   (wb_addr),
    .rd_a_en   (rd_a_en),
    .rd_a_addr (rd_a_addr),
    .rd_b_en   (rd_b_en),
    .rd_b_addr (rd_b_addr),
    .hit_a     (hit_a),
    .hit_b     (hit_b),
    .hazard    (hazard)
  );

  // R6: simultaneous physical writes land in different files
  p_swap_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (add_wr_phys && mul_wr_phys) |-> (add_wr_file != mul_wr_file));

  // R7: a write needs the pipe to execute
  p_write_needs_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (add_wr_phys || add_wr_acc || add_wr_io) |-> add_go);

  // R8: a live add op with a real condition owns the flags
  p_flag_from_add_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (f.op_add != '0) && (f.cond_add != 3'd0)) |-> !flag_src);

  // R5: the literal replaces the B read port
  p_lit_excludes_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lit_valid |-> !rd_b_en);

  // R10: no valid word, no activity
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !(add_go || mul_go || rd_a_en || rd_b_en || flag_we || hazard));

  // R9: a hazard is always tied to an enabled read
  p_hazard_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |-> ((hit_a && rd_a_en) || (hit_b && rd_b_en)));

endmodule

// File: tb/dualalu_decode_tb_top.sv
module dualalu_decode_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid, flag_z, flag_n, flag_c;
  logic [63:0] instr;
  logic [2:0]  iclass;
  logic        add_go, mul_go, rd_a_en, rd_b_en, lit_valid;
  logic [7:0]  src_kind;
  logic [11:0] src_acc;
  logic [5:0]  rd_a_addr, rd_b_addr, add_wr_addr, mul_wr_addr;
  logic [31:0] lit_value;
  logic        add_wr_phys, add_wr_acc, add_wr_io, add_wr_file;
  logic        mul_wr_phys, mul_wr_acc, mul_wr_io, mul_wr_file;
  logic        flag_we, flag_src, hazard;
  logic [4:0]  pack_ctl;

  dualalu_decode dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
    .iclass(iclass), .add_go(add_go), .mul_go(mul_go),
    .src_kind(src_kind), .src_acc(src_acc),
    .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr),
    .lit_valid(lit_valid), .lit_value(lit_value),
    .add_wr_phys(add_wr_phys), .add_wr_acc(add_wr_acc), .add_wr_io(add_wr_io),
    .add_wr_file(add_wr_file), .add_wr_addr(add_wr_addr),
    .mul_wr_phys(mul_wr_phys), .mul_wr_acc(mul_wr_acc), .mul_wr_io(mul_wr_io),
    .mul_wr_file(mul_wr_file), .mul_wr_addr(mul_wr_addr),
    .flag_we(flag_we), .flag_src(flag_src), .pack_ctl(pack_ctl), .hazard(hazard)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string req, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s]: actual %h expected %h", req, tag, act, exp);
    end
  endtask

  typedef struct {
    logic [2:0]  cls;
    logic [1:0]  go;
    logic [19:0] src;
    logic [13:0] rd;
    logic [32:0] lit;
    logic [1:0]  files;
    logic [17:0] wr;
    logic [1:0]  flg;
    logic [4:0]  pk;
    logic        hz;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  // bench-side record of the last accepted word's physical writes
  logic       bm_a_v = 1'b0, bm_b_v = 1'b0;
  logic [5:0] bm_a = '0, bm_b = '0;

  function automatic logic [63:0] mk(
    input logic [3:0] sg, input logic [2:0] up, input logic [2:0] ca, input logic [2:0] cm,
    input logic sf, input logic ws, input logic [5:0] wa, input logic [5:0] wm,
    input logic [2:0] om, input logic [4:0] oa, input logic [5:0] ra, input logic [5:0] rb,
    input logic [2:0] aa, input logic [2:0] ab, input logic [2:0] ma, input logic [2:0] mb);
    return {sg, up, 1'b1, 4'd4, ca, cm, sf, ws, wa, wm, om, oa, ra, rb, aa, ab, ma, mb};
  endfunction

  function automatic logic bm_cond(input logic [2:0] c, input logic z, input logic n, input logic cy);
    logic fl;
    if (c == 3'd0) return 1'b0;
    if (c == 3'd1) return 1'b1;
    fl = (c[2:1] == 2'd1) ? z : (c[2:1] == 2'd2) ? n : cy;
    return c[0] ? !fl : fl;
  endfunction

  function automatic logic [31:0] bm_lit(input logic [5:0] idx);
    int i;
    i = int'(idx);
    if (i <= 15) return 32'(i);
    if (i <= 31) return 32'(i - 32);
    if (i <= 39) return {1'b0, 8'(127 + i - 32), 23'd0};
    if (i <= 47) return {1'b0, 8'(127 + i - 48), 23'd0};
    return 32'd0;
  endfunction

  // {phys, acc, io, addr}
  function automatic logic [8:0] bm_dest(input logic go, input logic [5:0] a);
    logic ph, ac, io;
    ph = go && (a <= 6'd31);
    ac = go && (a >= 6'd32) && (a <= 6'd37);
    io = go && ((a == 6'd38) || (a >= 6'd40));
    return {ph, ac, io, a};
  endfunction

  task automatic send(input logic v, input logic [63:0] ins,
                      input logic z, input logic n, input logic cy, input string tag);
    exp_t e;
    logic [2:0] cls, code;
    logic       alu, live, lit, aact, mact, act, ws;
    logic [7:0] kinds;
    logic [11:0] accs;
    logic       ra_en, rb_en, lv;
    logic [5:0] ra, rb;
    logic [8:0] aw, mw;
    if (ins[63:60] == 4'd15)      cls = 3'd2;
    else if (ins[63:60] == 4'd14) cls = (ins[59:57] == 3'd4) ? 3'd4 : 3'd3;
    else if (ins[63:60] == 4'd13) cls = 3'd1;
    else                          cls = 3'd0;
    alu  = cls < 3'd2;
    live = v && alu;
    lit  = cls == 3'd1;
    aact = live && (ins[28:24] != 5'd0);
    mact = live && (ins[31:29] != 3'd0);
    e.cls = cls;
    e.go  = {aact && bm_cond(ins[51:49], z, n, cy), mact && bm_cond(ins[48:46], z, n, cy)};
    kinds = '0; accs = '0; ra_en = 0; rb_en = 0; lv = 0;
    for (int k = 0; k < 4; k++) begin
      code = ins[11 - 3*k -: 3];
      act  = (k < 2) ? aact : mact;
      kinds[2*k +: 2] = (code < 3'd6) ? 2'd0 : (code == 3'd6) ? 2'd1 : (lit ? 2'd3 : 2'd2);
      accs[3*k +: 3]  = (code < 3'd6) ? code : 3'd0;
      if (act && code == 3'd6) ra_en = 1;
      if (act && code == 3'd7 && !lit) rb_en = 1;
      if (act && code == 3'd7 && lit) lv = 1;
    end
    ra = ins[23:18];
    rb = ins[17:12];
    e.src = {kinds, accs};
    e.rd  = {ra_en, ra_en ? ra : 6'd0, rb_en, rb_en ? rb : 6'd0};
    e.lit = {lv, lv ? bm_lit(rb) : 32'd0};
    ws = ins[44];
    e.files = {ws, !ws};
    aw = bm_dest(e.go[1], ins[43:38]);
    mw = bm_dest(e.go[0], ins[37:32]);
    e.wr  = {aw, mw};
    e.flg = {live && ins[45], live && ins[45] && ((ins[28:24] == 5'd0) || (ins[51:49] == 3'd0))};
    e.pk  = live ? ins[56:52] : 5'd0;
    e.hz  = live && ((ra_en && ra <= 6'd31 && bm_a_v && bm_a == ra) ||
                     (rb_en && rb <= 6'd31 && bm_b_v && bm_b == rb));
    e.tag = tag;
    @(negedge clk);
    in_valid = v; instr = ins; flag_z = z; flag_n = n; flag_c = cy;
    exp_q.push_back(e);
    if (v) begin
      bm_a_v = (aw[8] && !ws) || (mw[8] && ws);
      bm_a   = (aw[8] && !ws) ? aw[5:0] : mw[5:0];
      bm_b_v = (aw[8] && ws) || (mw[8] && !ws);
      bm_b   = (aw[8] && ws) ? aw[5:0] : mw[5:0];
    end
  endtask

  // monitor: compares each queued expectation mid-cycle
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check("R1", e.tag, 64'(iclass), 64'(e.cls));
        check("R2", e.tag, 64'({add_go, mul_go}), 64'(e.go));
        check("R3", e.tag, 64'({src_kind, src_acc}), 64'(e.src));
        check("R4", e.tag, 64'({rd_a_en, rd_a_en ? rd_a_addr : 6'd0, rd_b_en, rd_b_en ? rd_b_addr : 6'd0}), 64'(e.rd));
        check("R5", e.tag, 64'({lit_valid, lit_valid ? lit_value : 32'd0}), 64'(e.lit));
        check("R6", e.tag, 64'({add_wr_file, mul_wr_file}), 64'(e.files));
        check("R7", e.tag, 64'({add_wr_phys, add_wr_acc, add_wr_io, add_wr_addr,
                                mul_wr_phys, mul_wr_acc, mul_wr_io, mul_wr_addr}), 64'(e.wr));
        check("R8", e.tag, 64'({flag_we, flag_src}), 64'(e.flg));
        check("R12", e.tag, 64'(pack_ctl), 64'(e.pk));
        check("R9", e.tag, 64'(hazard), 64'(e.hz));
      end
    end
  end

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  logic [63:0] w_wr, w_rd;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; flag_z = 0; flag_n = 0; flag_c = 0;
    repeat (2) @(negedge clk);
    #5;
    check("R11", "reset state", 64'({hazard, flag_we, rd_a_en, rd_b_en, add_go, mul_go}), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 dual issue with accumulators and both files
    send(1, mk(1,0, 1,1, 0,0, 32,33, 1,1, 15,35, 0,5,6,7), 0,0,0, "R3 acc and files");
    // R5 literal 1.0, R8 flags fall back to mul (NOP add, never)
    send(1, mk(13,0, 0,1, 1,1, 39,37, 1,0, 32,32, 6,7,6,7), 0,0,0, "R5 R8 literal one");
    send(1, mk(13,0, 1,1, 0,0, 39,39, 0,2, 0,15, 7,7,0,0), 0,0,0, "R5 idx 15");
    send(1, mk(13,0, 1,1, 0,0, 39,39, 0,2, 0,20, 7,7,0,0), 0,0,0, "R5 idx 20 negative");
    send(1, mk(13,0, 1,1, 0,0, 39,39, 0,2, 0,39, 7,7,0,0), 0,0,0, "R5 idx 39 max power");
    send(1, mk(13,0, 1,1, 0,0, 39,39, 0,2, 0,40, 7,7,0,0), 0,0,0, "R5 idx 40 smallest");
    send(1, mk(13,0, 1,1, 0,0, 39,39, 0,2, 0,47, 7,7,0,0), 0,0,0, "R5 idx 47 half");
    send(1, mk(13,0, 1,1, 0,0, 39,39, 0,2, 0,50, 7,7,0,0), 0,0,0, "R5 idx 50 reserved");

    w_wr = mk(1,0, 1,1, 0,0, 7,13, 1,1, 0,0, 0,1,2,3);
    w_rd = mk(1,0, 1,1, 0,0, 39,39, 1,1, 7,13, 6,0,0,7);
    send(1, w_wr, 0,0,0, "R6 unswapped writes");
    send(1, w_rd, 0,0,0, "R9 read after write");
    // swapped: r7 into B, r13 into A
    send(1, mk(1,0, 1,1, 0,1, 7,13, 1,1, 0,0, 0,1,2,3), 0,0,0, "R6 swapped writes");
    send(1, mk(1,0, 1,1, 0,0, 39,39, 1,1, 13,7, 6,0,0,7), 0,0,0, "R9 swapped hit");
    send(1, mk(1,0, 1,1, 0,1, 7,13, 1,1, 0,0, 0,1,2,3), 0,0,0, "R6 swapped writes again");
    send(1, w_rd, 0,0,0, "R9 swapped miss");

    // R2 conditions with R8 add still owning flags
    send(1, mk(1,0, 2,7, 1,0, 32,33, 1,1, 0,0, 0,1,2,3), 0,0,0, "R2 Z clear C clear");
    send(1, mk(1,0, 2,7, 1,0, 32,33, 1,1, 0,0, 0,1,2,3), 1,0,1, "R2 Z set C set");
    send(1, mk(1,0, 4,5, 0,0, 32,33, 1,1, 0,0, 0,1,2,3), 0,1,0, "R2 N set");
    // R4 NOP add pipe reading file A; R8 fallback with always cond
    send(1, mk(1,0, 1,1, 1,0, 39,34, 1,0, 9,0, 6,6,0,1), 0,0,0, "R4 R8 nop add");
    // R10 non-ALU classes
    send(1, mk(15,0, 1,1, 1,0, 3,4, 1,1, 5,6, 6,7,6,7), 0,0,0, "R10 branch");
    send(1, mk(14,4, 1,1, 1,0, 3,4, 1,1, 5,6, 6,7,6,7), 0,0,0, "R10 semaphore");
    send(1, mk(14,0, 1,1, 1,0, 3,4, 1,1, 5,6, 6,7,6,7), 0,0,0, "R10 load");
    send(0, w_wr, 0,0,0, "R10 not valid");
    // R7 IO-space destinations
    send(1, mk(1,0, 1,1, 0,0, 38,45, 1,1, 0,0, 0,1,2,3), 0,0,0, "R7 io writes");
    // R9 record held across an idle cycle
    send(1, w_wr, 0,0,0, "R9 writer");
    send(0, 64'd0, 0,0,0, "R9 bubble");
    send(1, w_rd, 0,0,0, "R9 across bubble");
    // R11 reset clears the record
    send(1, w_wr, 0,0,0, "R11 writer");
    send(0, 64'd0, 0,0,0, "R11 idle");
    @(negedge clk);
    rst_n = 1'b0;
    bm_a_v = 1'b0; bm_b_v = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    send(1, w_rd, 0,0,0, "R11 read after reset");
    send(0, 64'd0, 0,0,0, "R10 final idle");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule